// File: doc/BRIEF.md
# Clock-Independent Level Interrupt Collector

This block gathers level-sensitive interrupt requests from a parameterised group of external lines (eight by default) and presents them to a processor through a small word-addressed register bus. Each line has its own capture cell. The cell is set asynchronously as soon as the line sits at its programmed active level. A pulse is therefore recorded even while the bus clock is gated off, which suits wake-up and power-loss events. Software clears a cell by writing a one to its bit in the clear register. The clear takes effect on the bus clock.

Capture cells feed a two-stage synchronizer, and the raw status register shows the synchronizer output. The masked status register and the single interrupt output combine that raw status with a per-line enable. Capture itself does not depend on the enable, so an event that arrives while a line is disabled is still held and raises the interrupt as soon as the line is enabled. The block has a per-line polarity register in which 0 selects active-high and 1 selects active-low. A mode register is provided as plain read/write storage. No register returns the current level of the input lines.

Top module: `lvl_irq_bank`

## Requirements
- R1: After reset every readable register returns 0 and `irq_o` is low.
- R2: The word offsets are: enable 0x00, raw status 0x04, masked status 0x08, clear 0x0C, polarity 0x10, mode 0x14. Line n maps to data bit n. Enable, polarity and mode read back the low eight bits last written, and bits above the line count read as 0. The clear register, offsets 0x18 and 0x1C read as 0.
- R3: Line n is active when `evt_i[n]` differs from polarity bit n. With polarity 0 the line is active-high; with polarity 1 it is active-low.
- R4: An active level of any length, even one shorter than a clock period or one that arrives while the clock is stopped, sets the line's capture cell. The raw status bit reads 1 from the second rising clock edge after the cell is set, and not before.
- R5: Writing 1 to bit n of the clear register resets capture cell n at the next rising edge, and raw status bit n reads 0 from the third rising edge after the write edge. Bits written as 0 leave their lines untouched. If the line is still active, the bit stays at 1.
- R6: Masked status equals raw status AND enable. `irq_o` is high exactly when masked status is non-zero.
- R7: Writes to the raw and masked status offsets change no state.
- R8: The mode register has no effect on capture or on the interrupt.
- R9: A line captures while its enable bit is 0. Setting the enable bit later raises `irq_o` in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; may be stopped while events are captured |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | CH | Interrupt request lines, level sensitive |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address; the low two bits are ignored |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A capture cell stuck at 0 or 1, or a synchronizer stage that is skipped or doubled, shows up in the raw status read as a missing, sticky, early or late bit within three bus clock edges of the stimulus. The bench therefore samples raw status on both sides of the expected edge. A wrong polarity or enable register shows up at once in masked status and `irq_o` for the table patterns, which combine active-high and active-low lines. A clear that spills into neighbouring bits, or that fails to yield to a still-active line, shows up in the raw status read a few cycles after the clear write.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    // word index of each register (byte offset / 4)
    localparam int unsigned IDX_EN   = 0;
    localparam int unsigned IDX_RAW  = 1;
    localparam int unsigned IDX_MSK  = 2;
    localparam int unsigned IDX_CLR  = 3;
    localparam int unsigned IDX_POL  = 4;
    localparam int unsigned IDX_MODE = 5;
endpackage

// File: rtl/lvl_irq_cell.sv
// One capture cell: set asynchronously by an active line, cleared on the clock.
module lvl_irq_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic act_i,
    input  logic clr_i,
    output logic hit_o
);
    logic hit_q;

    always_ff @(posedge clk_i or negedge rst_ni or posedge act_i) begin
        if (!rst_ni)
            hit_q <= 1'b0;
        else if (act_i)
            hit_q <= 1'b1;
        else if (clr_i)
            hit_q <= 1'b0;
    end

    assign hit_o = hit_q;
endmodule

// File: rtl/lvl_irq_sync.sv
// Two-stage resynchronizer into the bus clock domain.
module lvl_irq_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            sync_q <= '0;
        else
            sync_q <= sync_d;
    end

    assign q_o = sync_q.s2;
endmodule

// File: rtl/lvl_irq_regs.sv
// Register file: enable, polarity, mode storage, clear pulse and read mux.
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int unsigned CH = 8,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [CH-1:0] raw_i,
    output logic [DW-1:0] rdata_o,
    output logic [CH-1:0] en_o,
    output logic [CH-1:0] pol_o,
    output logic [CH-1:0] clr_o,
    output logic          irq_o
);
    localparam int unsigned IW = AW - 2;

    typedef struct packed {
        logic [CH-1:0] en;
        logic [CH-1:0] pol;
        logic [CH-1:0] mode;
        logic [CH-1:0] clr;
    } regs_t;

    regs_t         regs_d, regs_q;
    logic [IW-1:0] widx;
    logic [CH-1:0] msk;
    logic          unused_bits;

    assign widx        = addr_i[AW-1:2];
    assign msk         = raw_i & regs_q.en;
    assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:CH]};

    always_comb begin
        regs_d     = regs_q;
        regs_d.clr = '0;
        if (sel_i && wr_i) begin
            case (widx)
                IW'(IDX_EN):   regs_d.en   = wdata_i[CH-1:0];
                IW'(IDX_CLR):  regs_d.clr  = wdata_i[CH-1:0];
                IW'(IDX_POL):  regs_d.pol  = wdata_i[CH-1:0];
                IW'(IDX_MODE): regs_d.mode = wdata_i[CH-1:0];
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            case (widx)
                IW'(IDX_EN):   rdata_o[CH-1:0] = regs_q.en;
                IW'(IDX_RAW):  rdata_o[CH-1:0] = raw_i;
                IW'(IDX_MSK):  rdata_o[CH-1:0] = msk;
                IW'(IDX_POL):  rdata_o[CH-1:0] = regs_q.pol;
                IW'(IDX_MODE): rdata_o[CH-1:0] = regs_q.mode;
                default:       rdata_o = '0;
            endcase
        end
    end

    assign en_o  = regs_q.en;
    assign pol_o = regs_q.pol;
    assign clr_o = regs_q.clr;
    assign irq_o = |msk;
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank #(
    parameter int unsigned CH = 8,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CH-1:0] evt_i,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    logic [CH-1:0] act_w;
    logic [CH-1:0] hit_w;
    logic [CH-1:0] raw_w;
    logic [CH-1:0] en_w;
    logic [CH-1:0] pol_w;
    logic [CH-1:0] clr_w;

    assign act_w = evt_i ^ pol_w;

    for (genvar g = 0; g < CH; g++) begin : g_cell
        lvl_irq_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .act_i  (act_w[g]),
            .clr_i  (clr_w[g]),
            .hit_o  (hit_w[g])
        );
    end

    lvl_irq_sync #(.W(CH)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (hit_w),
        .q_o    (raw_w)
    );

    lvl_irq_regs #(.CH(CH), .DW(DW), .AW(AW)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .raw_i   (raw_w),
        .rdata_o (rdata_o),
        .en_o    (en_w),
        .pol_o   (pol_w),
        .clr_o   (clr_w),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/lvl_irq_bank_chk.sv
module lvl_irq_bank_chk
    import lvl_irq_pkg::*;
#(
    parameter int unsigned CH = 8,
    parameter int unsigned IW = 3
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          sel_i,
    input logic          wr_i,
    input logic [IW-1:0] idx_i,
    input logic [CH-1:0] hit_i,
    input logic [CH-1:0] raw_i,
    input logic [CH-1:0] clr_i,
    input logic [CH-1:0] en_i,
    input logic [CH-1:0] pol_i,
    input logic          irq_i
);
    // a raw bit may only rise if its capture cell was set two samples earlier
    assert_raw_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((raw_i & ~$past(raw_i)) & ~$past(hit_i, 2)) == '0);

    // a capture cell only drops after a clear pulse on that line
    assert_cell_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~hit_i & $past(hit_i)) & ~$past(clr_i)) == '0);

    // a clear pulse only follows a write to the clear offset
    assert_clear_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i != '0) |-> $past(sel_i && wr_i && idx_i == IW'(IDX_CLR)));

    // no interrupt without a raw status bit
    assert_irq_needs_raw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raw_i == '0) |-> !irq_i);

    // polarity and enable hold unless written at their own offsets
    assert_pol_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel_i && wr_i && idx_i == IW'(IDX_POL)) |=> $stable(pol_i));

    assert_en_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel_i && wr_i && idx_i == IW'(IDX_EN)) |=> $stable(en_i));
endmodule

bind lvl_irq_bank lvl_irq_bank_chk #(.CH(CH), .IW(AW-2)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .wr_i   (wr_i),
    .idx_i  (addr_i[AW-1:2]),
    .hit_i  (hit_w),
    .raw_i  (raw_w),
    .clr_i  (clr_w),
    .en_i   (en_w),
    .pol_i  (pol_w),
    .irq_i  (irq_o)
);

// File: tb/lvl_irq_bank_tb.sv
module lvl_irq_bank_tb;
    localparam logic [4:0] A_EN = 5'h00, A_RAW = 5'h04, A_MSK = 5'h08,
                           A_CLR = 5'h0C, A_POL = 5'h10, A_MODE = 5'h14;

    // {pattern, polarity, enable, expected raw, expected masked}
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {8'h01, 8'h00, 8'hFF, 8'h01, 8'h01},
        {8'h80, 8'h80, 8'h00, 8'h80, 8'h00},
        {8'h5A, 8'hF0, 8'h0F, 8'h5A, 8'h0A},
        {8'hFF, 8'hFF, 8'hA5, 8'hFF, 8'hA5},
        {8'h00, 8'h3C, 8'hFF, 8'h00, 8'h00},
        {8'h24, 8'h00, 8'h20, 8'h24, 8'h20}
    };

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [31:0] rd;
    logic [7:0]  cur_pol = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always begin
        #5;
        if (clk_run) clk = ~clk;
    end

    lvl_irq_bank u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .evt_i   (evt),
        .sel_i   (sel),
        .wr_i    (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] pat);
        #1 evt = cur_pol ^ pat;
        #2 evt = cur_pol;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_rd(A_EN, rd);   chk("R1 enable", rd, 0);
        bus_rd(A_RAW, rd);  chk("R1 raw", rd, 0);
        bus_rd(A_MSK, rd);  chk("R1 masked", rd, 0);
        bus_rd(A_POL, rd);  chk("R1 polarity", rd, 0);
        bus_rd(A_MODE, rd); chk("R1 mode", rd, 0);
        chk("R1 irq", 32'(irq), 0);

        // R3 R6: table of patterns
        for (int i = 0; i < NV; i++) begin
            bus_wr(A_POL, 32'(VEC[i][31:24]));
            cur_pol = VEC[i][31:24];
            evt = cur_pol;
            bus_wr(A_CLR, 32'hFF);
            bus_wr(A_EN, 32'(VEC[i][23:16]));
            pulse(VEC[i][39:32]);
            settle(3);
            bus_rd(A_RAW, rd); chk("R3 raw vector", rd, 32'(VEC[i][15:8]));
            bus_rd(A_MSK, rd); chk("R6 masked vector", rd, 32'(VEC[i][7:0]));
            chk("R6 irq vector", 32'(irq), 32'(VEC[i][7:0] != 0));
        end

        // back to active-high, all cleared
        bus_wr(A_POL, 0); cur_pol = '0; evt = '0;
        bus_wr(A_CLR, 32'hFF);
        bus_wr(A_EN, 32'h08);
        settle(4);

        // R4: capture with the clock stopped, then two-edge latency
        clk_run = 1'b0;
        #10 evt = 8'h08;
        #3  evt = 8'h00;
        #40;
        chk("R4 irq while clock stopped", 32'(irq), 0);
        clk_run = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd(A_RAW, rd); chk("R4 raw after first edge", rd, 0);
        @(posedge clk); @(negedge clk);
        bus_rd(A_RAW, rd); chk("R4 raw after second edge", rd, 32'h08);
        chk("R4 irq after second edge", 32'(irq), 1);

        // R5: clear timing
        bus_wr(A_CLR, 32'h08);
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_rd(A_RAW, rd); chk("R5 raw two edges after clear", rd, 32'h08);
        @(posedge clk); @(negedge clk);
        bus_rd(A_RAW, rd); chk("R5 raw three edges after clear", rd, 0);
        chk("R5 irq after clear", 32'(irq), 0);

        // R5: clear while the line is still active
        evt = 8'h08;
        settle(3);
        bus_wr(A_CLR, 32'h08);
        settle(5);
        bus_rd(A_RAW, rd); chk("R5 raw while line held active", rd, 32'h08);
        evt = 8'h00;
        bus_wr(A_CLR, 32'h08);
        settle(4);
        bus_rd(A_RAW, rd); chk("R5 raw after release and clear", rd, 0);

        // R5: zero bits in the clear word leave other lines alone
        pulse(8'h30);
        settle(3);
        bus_wr(A_CLR, 32'h10);
        settle(4);
        bus_rd(A_RAW, rd); chk("R5 partial clear", rd, 32'h20);

        // R7: writes to status offsets ignored
        bus_wr(A_RAW, 32'h0);
        bus_wr(A_MSK, 32'hFF);
        settle(3);
        bus_rd(A_RAW, rd); chk("R7 raw after write", rd, 32'h20);
        bus_rd(A_EN, rd);  chk("R7 enable after status write", rd, 32'h08);

        // R8: mode is storage only
        bus_wr(A_MODE, 32'hA5);
        bus_rd(A_MODE, rd); chk("R8 mode readback", rd, 32'hA5);
        bus_wr(A_CLR, 32'hFF);
        settle(3);
        pulse(8'h01);
        settle(3);
        bus_rd(A_RAW, rd); chk("R8 capture with mode set", rd, 32'h01);

        // R9: capture while disabled, interrupt once enabled
        bus_wr(A_EN, 0);
        bus_wr(A_CLR, 32'hFF);
        settle(3);
        pulse(8'h40);
        settle(3);
        bus_rd(A_RAW, rd); chk("R9 raw while disabled", rd, 32'h40);
        bus_rd(A_MSK, rd); chk("R9 masked while disabled", rd, 0);
        chk("R9 irq while disabled", 32'(irq), 0);
        bus_wr(A_EN, 32'h40);
        chk("R9 irq after enable", 32'(irq), 1);
        bus_rd(A_MSK, rd); chk("R9 masked after enable", rd, 32'h40);

        // R2: upper bits, clear readback, unmapped offsets
        bus_wr(A_EN, 32'hFFFF_FFFF);
        bus_rd(A_EN, rd);  chk("R2 enable upper bits", rd, 32'hFF);
        bus_rd(A_CLR, rd); chk("R2 clear reads zero", rd, 0);
        bus_rd(5'h18, rd); chk("R2 offset 0x18", rd, 0);
        bus_rd(5'h1C, rd); chk("R2 offset 0x1C", rd, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule